// File: doc/BRIEF.md
# Identification Arbitration Transmitter for a Shared Open-Drain Command Line

This block sends a card's identification word onto a command line that several cards share as a wired-AND. While it transmits a bit of value 0 it pulls the line low. While it transmits a bit of value 1 it releases the line. The word goes out most significant bit first, one bit per clock.

At the end of every bit period the block samples the line level it receives and compares that level with the bit it drove. A difference means another card is pulling the line low. When that happens, this card has lost the arbitration: it releases the line at once and raises a lost flag. If all bits go out without a difference, the card raises a won flag. The surrounding card logic uses that flag to move on to the identification state.

A start request begins each identification cycle and clears both flags. A losing card waits for the next start request and can then arbitrate again. The response framing bits and the card state machine are supplied outside this block.

Top module: `idarb_tx`

## Requirements
- R1: Reset is synchronous and active-high. One clock after reset is sampled high, `pull_low_o`, `won_o` and `lost_o` are all 0.
- R2: On a clock edge where `start_i` is 1, the block captures `id_word_i`. From that edge on, `pull_low_o` drives the inverse of bit ID_W-1, so 1 pulls the line low for a 0 bit. On each following edge the block presents the next lower bit, MSB first, one bit per clock.
- R3: Each bit is driven for one clock, and the block samples `line_i` at the edge that ends that bit. If the sampled `line_i` differs from the driven bit, counting a released line as 1, then at that edge `lost_o` goes to 1 and `pull_low_o` goes to 0, and no further bits are driven.
- R4: If all ID_W bits are sampled without a difference, then at the edge that samples bit 0 `won_o` goes to 1 and `pull_low_o` goes to 0.
- R5: `won_o` and `lost_o` are never 1 together. Once set, each flag holds until the next start request or reset.
- R6: A start request clears both flags at the edge where it is sampled. It restarts transmission from the MSB of the new word, even in the middle of a transmission.
- R7: While no transmission is in progress, `line_i` has no effect: `pull_low_o` stays 0 and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an arbitration round with `id_word_i` |
| id_word_i | input | ID_W | Identification word to send |
| line_i | input | 1 | Sampled level of the shared command line |
| pull_low_o | output | 1 | Open-drain enable; 1 pulls the line low |
| won_o | output | 1 | Whole word sent without a mismatch |
| lost_o | output | 1 | A mismatch was seen and the card withdrew |

## Verification
The assertions check on every cycle the properties that hold at any time:
- a mismatch while sending leads to withdrawal and a lost flag on the next cycle;
- the two flags are exclusive and hold until the next start;
- a start clears both flags;
- an idle block never pulls the line low.

Only the bench's scenarios can show that the exact bit sequence comes out MSB first. The same is true of the loss landing on the first bit where a competing card pulls a released line low, and of a tie or an all-zero word running to a win after exactly ID_W bits. The bench shows these by modelling a second card on the wired-AND line.

// File: rtl/idarb_pkg.sv
package idarb_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_SEND = 1'b1
  } arb_state_t;
endpackage

// File: rtl/idarb_shreg.sv
module idarb_shreg #(
  parameter int ID_W = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic            shift_i,
  input  logic [ID_W-1:0] word_i,
  output logic            next_bit_o,
  output logic            last_o
);
  localparam int CNT_W = $clog2(ID_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ID_W - 1);

  logic [ID_W-1:0]  sreg;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (load_i) begin
      sreg <= word_i;
      cnt  <= '0;
    end else if (shift_i) begin
      sreg <= {sreg[ID_W-2:0], 1'b0};
      cnt  <= cnt + 1'b1;
    end
  end

  assign next_bit_o = sreg[ID_W-2];
  assign last_o     = (cnt == LAST_IDX);

  // R2: the bit counter never runs past the final bit
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    shift_i |-> (cnt != LAST_IDX));
endmodule

// File: rtl/idarb_cmp.sv
module idarb_cmp (
  input  logic sample_en_i,
  input  logic pull_low_i,
  input  logic line_i,
  output logic mismatch_o
);
  logic driven_bit;
  assign driven_bit = ~pull_low_i;
  assign mismatch_o = sample_en_i & (line_i != driven_bit);
endmodule

// File: rtl/idarb_tx.sv
module idarb_tx
  import idarb_pkg::*;
#(
  parameter int ID_W = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [ID_W-1:0] id_word_i,
  input  logic            line_i,
  output logic            pull_low_o,
  output logic            won_o,
  output logic            lost_o
);
  arb_state_t state;
  logic sending, mismatch, last_bit, next_bit, do_shift;

  assign sending  = (state == ARB_SEND);
  assign do_shift = sending & ~start_i & ~mismatch & ~last_bit;

  idarb_shreg #(.ID_W(ID_W)) u_shreg (
    .clk        (clk),
    .rst        (rst),
    .load_i     (start_i),
    .shift_i    (do_shift),
    .word_i     (id_word_i),
    .next_bit_o (next_bit),
    .last_o     (last_bit)
  );

  idarb_cmp u_cmp (
    .sample_en_i (sending),
    .pull_low_i  (pull_low_o),
    .line_i      (line_i),
    .mismatch_o  (mismatch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ARB_IDLE;
      pull_low_o <= 1'b0;
      won_o      <= 1'b0;
      lost_o     <= 1'b0;
    end else if (start_i) begin
      state      <= ARB_SEND;
      pull_low_o <= ~id_word_i[ID_W-1];
      won_o      <= 1'b0;
      lost_o     <= 1'b0;
    end else if (sending) begin
      if (mismatch) begin
        state      <= ARB_IDLE;
        pull_low_o <= 1'b0;
        lost_o     <= 1'b1;
      end else if (last_bit) begin
        state      <= ARB_IDLE;
        pull_low_o <= 1'b0;
        won_o      <= 1'b1;
      end else begin
        pull_low_o <= ~next_bit;
      end
    end
  end

  // R3: a sampled mismatch withdraws the card on the next cycle
  a_r3_withdraw_on_mismatch: assert property (@(posedge clk) disable iff (rst)
    (sending && !start_i && (line_i == pull_low_o)) |=> (lost_o && !pull_low_o));
  // R4: a win always leaves the line released
  a_r4_win_releases: assert property (@(posedge clk) disable iff (rst)
    $rose(won_o) |-> !pull_low_o);
  // R5: flags are exclusive
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(won_o && lost_o));
  // R5: flags hold until a start
  a_r5_won_holds: assert property (@(posedge clk) disable iff (rst)
    (won_o && !start_i) |=> won_o);
  a_r5_lost_holds: assert property (@(posedge clk) disable iff (rst)
    (lost_o && !start_i) |=> lost_o);
  // R6: a start clears both flags
  a_r6_start_clears: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (!won_o && !lost_o));
  // R7: an idle block never pulls the line low
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!sending && !start_i) |=> !pull_low_o);
endmodule

// File: tb/sim_idarb_tx.sv
`timescale 1ns/1ps
module sim_idarb_tx;
  localparam int ID_W = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [ID_W-1:0] id_word_i = '0;
  logic line_i = 1'b1;
  logic pull_low_o, won_o, lost_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  idarb_tx #(.ID_W(ID_W)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .id_word_i(id_word_i),
    .line_i(line_i), .pull_low_o(pull_low_o), .won_o(won_o), .lost_o(lost_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Index of the bit where this card loses, or -1 when it wins
  function automatic int lose_index(input logic [ID_W-1:0] a, input logic [ID_W-1:0] b);
    for (int k = 0; k < ID_W; k++) begin
      if (a[ID_W-1-k] != b[ID_W-1-k]) return a[ID_W-1-k] ? k : -1;
    end
    return -1;
  endfunction

  function automatic logic [ID_W-1:0] rand_word();
    logic [ID_W-1:0] w;
    for (int i = 0; i < ID_W/32; i++) w[i*32 +: 32] = $urandom;
    return w;
  endfunction

  // Arbitrate word a against a competing card sending b
  task automatic run_arb(input logic [ID_W-1:0] a, input logic [ID_W-1:0] b);
    int  lk;
    bit  other_in;
    logic other_pull;
    lk = lose_index(a, b);
    other_in = 1'b1;
    @(negedge clk);
    start_i = 1'b1; id_word_i = a; line_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!won_o && !lost_o, "R6 flags cleared by start", {won_o, lost_o}, 0);
    for (int k = 0; k < ID_W; k++) begin
      chk(pull_low_o == !a[ID_W-1-k], "R2 driven bit", pull_low_o, !a[ID_W-1-k]);
      other_pull = other_in && !b[ID_W-1-k];
      line_i = !(pull_low_o | other_pull);
      if (other_in && b[ID_W-1-k] && !line_i) other_in = 1'b0;
      @(negedge clk);
      if (k == lk) begin
        chk(lost_o && !won_o && !pull_low_o, "R3 lost at mismatch", {lost_o, won_o, pull_low_o}, 3'b100);
        line_i = 1'b1;
        return;
      end
    end
    line_i = 1'b1;
    chk(won_o && !lost_o && !pull_low_o, "R4 won after full word", {won_o, lost_o, pull_low_o}, 3'b100);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [ID_W-1:0] a, b;
    bit fw, fl;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk(!pull_low_o && !won_o && !lost_o, "R1 reset state", {pull_low_o, won_o, lost_o}, 0);

    // R7: line activity while idle has no effect
    for (int i = 0; i < 6; i++) begin
      line_i = i[0];
      @(negedge clk);
      chk(!pull_low_o && !won_o && !lost_o, "R7 idle ignores line", {pull_low_o, won_o, lost_o}, 0);
    end
    line_i = 1'b1;

    // Directed corners
    run_arb('0, '1);                                   // R4 all zeros always win
    run_arb('1, {{(ID_W-1){1'b1}}, 1'b0});              // R3 loss on final bit
    run_arb({1'b1, {(ID_W-1){1'b0}}}, '0);              // R3 loss on first bit
    a = rand_word();
    run_arb(a, a);                                     // R4 tie wins

    // R5: lost flag holds while idle and line toggles
    run_arb('1, '0);
    for (int i = 0; i < 4; i++) begin
      line_i = i[0];
      @(negedge clk);
      chk(lost_o && !won_o && !pull_low_o, "R5 lost holds / R7", {lost_o, won_o, pull_low_o}, 3'b100);
    end
    line_i = 1'b1;

    // R6: restart mid-transmission
    @(negedge clk);
    start_i = 1'b1; id_word_i = '1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 9; i++) begin line_i = !pull_low_o; @(negedge clk); end
    line_i = 1'b1;
    a = rand_word();
    run_arb(a, a ^ ({{(ID_W-1){1'b0}}, 1'b1} << 100));

    // Random rounds
    for (int r = 0; r < 40; r++) begin
      a = rand_word();
      case ($urandom % 3)
        0: b = rand_word();
        1: b = a ^ ({{(ID_W-1){1'b0}}, 1'b1} << ($urandom % ID_W));
        default: b = a;
      endcase
      run_arb(a, b);
      fw = won_o; fl = lost_o;
      @(negedge clk);
      chk(won_o == fw && lost_o == fl, "R5 flags hold", {won_o, lost_o}, {fw, fl});
    end

    // R1: synchronous reset clears everything mid-run
    @(negedge clk);
    start_i = 1'b1; id_word_i = '0;
    @(negedge clk);
    start_i = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!pull_low_o && !won_o && !lost_o, "R1 reset mid-run", {pull_low_o, won_o, lost_o}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule